// File: doc/BRIEF.md
# Quad Channel Enable Controller

This block decides, for each of four power-switch channels, whether the gate driver may turn that channel on. Each channel takes a two-of-three vote over two enable bits held in a register and one external ON level. With this vote, either a pin or software can control a channel. If both enable bits are set, software can force the channel on. If both are cleared, software can force it off. The second enable bit of every channel gets its start value from a hardware-enable pin. That pin is sampled at the moment the input supply leaves undervoltage lockout. So a board can pick whether the channels follow their ON pins from power-up.

The block also holds a read-only status register and a sticky fault register. The status register mirrors the synchronized ON levels, the grouping mode and the selected fault response. It applies one of three responses to a critical undervoltage or overvoltage event on a channel:
- alert only;
- alert plus withdrawal of power-good;
- alert, power-good withdrawal and a latched shutdown of the channel.

A latched shutdown is released only after software clears both enable bits of that channel and then sets them again. Register access is a single-cycle synchronous write with a combinational read.

Top module: `quad_chan_enable`

## Requirements
- R1: For each channel n (0 to 3), `gate_on[n]` is 1 exactly when `uvlo_ok` is 1, the channel has no latched shutdown, and at least two of EN1[n], EN2[n] and the synchronized ON[n] are 1.
- R2: While `uvlo_ok` is 0, `gate_on` is 0 for all channels. This holds in the same cycle, with no register delay.
- R3: The enable register is at address 0x69 and is read/write. Bit 2n holds EN1 and bit 2n+1 holds EN2 of channel n. A write takes effect at the clock edge where `reg_we` is high. Its reset value is 0x00.
- R4: In the first clock after `uvlo_ok` goes from 0 to 1, the enable register loads 0xAA if `hw_en` is 1 and 0x00 if it is 0. This load wins over a register write in the same cycle.
- R5: The status register is at address 0x60. Bits [3:0] hold the synchronized ON levels. Bits [5:4] hold the grouping code (00 grouped, 01 paired, 10 independent). Bits [7:6] hold the response code (00 alert, 01 alert and power-good drop, 10 alert, power-good drop and shutdown).
- R6: The ON, grouping and response inputs each pass through a two-flop synchronizer. A change on them reaches the outputs after the second clock edge, not the first.
- R7: Writes to address 0x60 have no effect. Reads of any address other than 0x60, 0x69 and 0x6C return 0x00.
- R8: The fault register is at address 0x6C. Bit n is set in the clock after `fault_crit[n]` is 1 and stays set. Writing 1 to bit n clears it, and a set in the same cycle wins over the clear. Bits [7:4] read 0. `alert` is 1 whenever any fault bit is set.
- R9: With response code 00, `pg_ok` equals `gate_on`. With any other code, `pg_ok[n]` is 0 while fault bit n is set.
- R10: With response code 10, a critical event on channel n forces `gate_on[n]` to 0 from the next clock. It stays 0 until the channel's two enable bits have been seen as 00 and are then written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_ok | input | 1 | Supply is above the undervoltage lockout level |
| hw_en | input | 1 | Hardware-enable pin level, sampled when lockout releases |
| on_lvl | input | 4 | Digitized ON level per channel |
| grp_lvl | input | 2 | Digitized grouping mode code |
| rsp_lvl | input | 2 | Digitized critical-fault response code |
| fault_crit | input | 4 | Critical undervoltage/overvoltage event per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| gate_on | output | 4 | Gate-on request per channel |
| pg_ok | output | 4 | Power-good permission per channel |
| alert | output | 1 | Any sticky fault flag is set |

## Verification
Most internal state shows up on `gate_on` within one clock. The enable register and the latched shutdown feed that output through combinational logic only. A bad enable-register load at lockout release shows up at once as a wrong vote. It also shows up on the next read of 0x69. A synchronizer with the wrong depth shows up as an output change one edge early or late, so the bench samples both after the first edge and after the second. A fault flag or shutdown latch that is set or released wrongly shows up in the cycle after the event or write: on `alert`, on `pg_ok` and on `gate_on`.

// File: rtl/qce_pkg.sv
package qce_pkg;

    localparam int NCH    = 4;
    localparam int RW     = 2 * NCH;
    localparam int ADDR_W = 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h60;
    localparam logic [ADDR_W-1:0] ADDR_EN   = 8'h69;
    localparam logic [ADDR_W-1:0] ADDR_FLT  = 8'h6C;

    typedef enum logic [1:0] {
        GRP_ALL   = 2'b00,
        GRP_PAIR  = 2'b01,
        GRP_INDEP = 2'b10,
        GRP_BAD   = 2'b11
    } grp_e;

    typedef enum logic [1:0] {
        RSP_ALERT = 2'b00,
        RSP_PG    = 2'b01,
        RSP_OFF   = 2'b10,
        RSP_BAD   = 2'b11
    } rsp_e;

    typedef struct packed {
        rsp_e           rsp;
        grp_e           grp;
        logic [NCH-1:0] on;
    } stat_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [RW-1:0] en_boot(input logic hw);
        logic [RW-1:0] v;
        v = '0;
        for (int i = 0; i < NCH; i++) begin
            v[2*i+1] = hw;
        end
        return v;
    endfunction

    function automatic logic rsp_drops_pg(input rsp_e r);
        return r != RSP_ALERT;
    endfunction

    function automatic logic rsp_shuts(input rsp_e r);
        return (r == RSP_OFF) || (r == RSP_BAD);
    endfunction

endpackage

// File: rtl/qce_sync.sv
module qce_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/qce_en_reg.sv
module qce_en_reg
    import qce_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          uvlo_ok,
    input  logic          hw_en,
    input  logic          wr,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] en_q
);

    logic uvlo_q;
    logic release_edge;

    assign release_edge = uvlo_ok & ~uvlo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            uvlo_q <= 1'b0;
            en_q   <= '0;
        end else begin
            uvlo_q <= uvlo_ok;
            if (release_edge) begin
                en_q <= en_boot(hw_en);
            end else if (wr) begin
                en_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/qce_fault.sv
module qce_fault
    import qce_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] fault_crit,
    input  rsp_e           rsp,
    input  logic           clr_wr,
    input  logic [NCH-1:0] clr_mask,
    input  logic [NCH-1:0] pair_zero,
    output logic [NCH-1:0] flt,
    output logic [NCH-1:0] lock
);

    logic shut_mode;
    assign shut_mode = rsp_shuts(rsp);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                flt[n]  <= 1'b0;
                lock[n] <= 1'b0;
            end else begin
                if (fault_crit[n]) begin
                    flt[n] <= 1'b1;
                end else if (clr_wr && clr_mask[n]) begin
                    flt[n] <= 1'b0;
                end

                if (fault_crit[n] && shut_mode) begin
                    lock[n] <= 1'b1;
                end else if (pair_zero[n]) begin
                    lock[n] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/quad_chan_enable.sv
module quad_chan_enable
    import qce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              uvlo_ok,
    input  logic              hw_en,
    input  logic [NCH-1:0]    on_lvl,
    input  logic [1:0]        grp_lvl,
    input  logic [1:0]        rsp_lvl,
    input  logic [NCH-1:0]    fault_crit,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    output logic [NCH-1:0]    gate_on,
    output logic [NCH-1:0]    pg_ok,
    output logic              alert
);

    localparam int STAT_W = $bits(stat_t);

    stat_t          stat_s;
    logic [1:0]     prot_s;
    logic [RW-1:0]  en_q;
    logic [NCH-1:0] flt;
    logic [NCH-1:0] lock;
    logic [NCH-1:0] pair_zero;
    logic [NCH-1:0] vote;

    qce_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({rsp_lvl, grp_lvl, on_lvl}),
        .q   (stat_s)
    );

    assign prot_s = stat_s.rsp;

    qce_en_reg u_en (
        .clk     (clk),
        .rst     (rst),
        .uvlo_ok (uvlo_ok),
        .hw_en   (hw_en),
        .wr      (reg_we && (reg_addr == ADDR_EN)),
        .wdata   (reg_wdata),
        .en_q    (en_q)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_vote
        assign pair_zero[n] = ~en_q[2*n] & ~en_q[2*n+1];
        assign vote[n]      = maj3(en_q[2*n], en_q[2*n+1], stat_s.on[n]);
    end

    qce_fault u_fault (
        .clk        (clk),
        .rst        (rst),
        .fault_crit (fault_crit),
        .rsp        (stat_s.rsp),
        .clr_wr     (reg_we && (reg_addr == ADDR_FLT)),
        .clr_mask   (reg_wdata[NCH-1:0]),
        .pair_zero  (pair_zero),
        .flt        (flt),
        .lock       (lock)
    );

    assign gate_on = {NCH{uvlo_ok}} & vote & ~lock;
    assign pg_ok   = gate_on & ~(flt & {NCH{rsp_drops_pg(stat_s.rsp)}});
    assign alert   = |flt;

    always_comb begin
        case (reg_addr)
            ADDR_STAT: reg_rdata = stat_s;
            ADDR_EN:   reg_rdata = en_q;
            ADDR_FLT:  reg_rdata = {{(RW-NCH){1'b0}}, flt};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/quad_chan_enable_chk.sv
module quad_chan_enable_chk
    import qce_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              uvlo_ok,
    input logic              hw_en,
    input logic [NCH-1:0]    fault_crit,
    input logic [NCH-1:0]    gate_on,
    input logic [NCH-1:0]    pg_ok,
    input logic              alert,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [RW-1:0]     reg_rdata,
    input logic [RW-1:0]     en_q,
    input logic [1:0]        prot_s
);

    a_r2_off_in_lockout: assert property (@(posedge clk) disable iff (rst)
        !uvlo_ok |-> (gate_on == '0));

    a_r4_boot_load: assert property (@(posedge clk) disable iff (rst)
        $rose(uvlo_ok) |=> (en_q == ($past(hw_en) ? en_boot(1'b1) : en_boot(1'b0))));

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != ADDR_STAT && reg_addr != ADDR_EN && reg_addr != ADDR_FLT)
            |-> (reg_rdata == '0));

    a_r8_alert_after_fault: assert property (@(posedge clk) disable iff (rst)
        (|fault_crit) |=> alert);

    a_r9_pg_follows_gate: assert property (@(posedge clk) disable iff (rst)
        (prot_s == 2'b00) |-> (pg_ok == gate_on));

    a_r10_shutdown: assert property (@(posedge clk) disable iff (rst)
        ((|fault_crit) && prot_s[1]) |=> ((gate_on & $past(fault_crit)) == '0));

endmodule

bind quad_chan_enable quad_chan_enable_chk u_chk (.*);

// File: tb/quad_chan_enable_tb.sv
module quad_chan_enable_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       uvlo_ok;
    logic       hw_en;
    logic [3:0] on_lvl;
    logic [1:0] grp_lvl;
    logic [1:0] rsp_lvl;
    logic [3:0] fault_crit;
    logic       reg_we;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [3:0] gate_on;
    logic [3:0] pg_ok;
    logic       alert;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    quad_chan_enable u_dut (
        .clk        (clk),
        .rst        (rst),
        .uvlo_ok    (uvlo_ok),
        .hw_en      (hw_en),
        .on_lvl     (on_lvl),
        .grp_lvl    (grp_lvl),
        .rsp_lvl    (rsp_lvl),
        .fault_crit (fault_crit),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .gate_on    (gate_on),
        .pg_ok      (pg_ok),
        .alert      (alert)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 8'h00;
    endtask

    task automatic pulse_fault(input logic [3:0] f);
        fault_crit = f;
        tick(1);
        fault_crit = 4'h0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R2 reset gate", {4'h0, gate_on}, 8'h00);
        check("R8 reset alert", {7'h0, alert}, 8'h00);
        rd(8'h69, v);
        check("R3 reset enable reg", v, 8'h00);
    endtask

    task automatic t_boot_high();
        logic [7:0] v;
        uvlo_ok = 1'b1;
        tick(1);
        rd(8'h69, v);
        check("R4 boot load hw_en=1", v, 8'hAA);
        check("R1 EN2 only, ON low", {4'h0, gate_on}, 8'h00);
    endtask

    task automatic t_sync_latency();
        logic [7:0] v;
        on_lvl = 4'hF;
        tick(1);
        check("R6 one edge after ON", {4'h0, gate_on}, 8'h00);
        tick(1);
        check("R6 two edges after ON", {4'h0, gate_on}, 8'h0F);
        rd(8'h60, v);
        check("R5 status ON bits", {4'h0, v[3:0]}, 8'h0F);
    endtask

    task automatic t_majority();
        logic [7:0] v;
        wr(8'h69, 8'h55);
        check("R1 EN1 and ON", {4'h0, gate_on}, 8'h0F);
        on_lvl = 4'h0; tick(3);
        check("R1 EN1 only", {4'h0, gate_on}, 8'h00);
        wr(8'h69, 8'hFF);
        check("R1 EN1 and EN2", {4'h0, gate_on}, 8'h0F);
        wr(8'h69, 8'h09);
        on_lvl = 4'h3; tick(3);
        check("R1 mixed votes", {4'h0, gate_on}, 8'h03);
        rd(8'h69, v);
        check("R3 readback", v, 8'h09);
    endtask

    task automatic t_lockout();
        logic [7:0] v;
        wr(8'h69, 8'hFF);
        on_lvl = 4'hF; tick(3);
        uvlo_ok = 1'b0;
        #1;
        check("R2 lockout same cycle", {4'h0, gate_on}, 8'h00);
        tick(2);
        check("R2 lockout held", {4'h0, gate_on}, 8'h00);
        hw_en = 1'b0;
        uvlo_ok = 1'b1;
        reg_we = 1'b1; reg_addr = 8'h69; reg_wdata = 8'h33;
        tick(1);
        reg_we = 1'b0;
        rd(8'h69, v);
        check("R4 boot load hw_en=0 over write", v, 8'h00);
        check("R1 after boot low", {4'h0, gate_on}, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] v;
        grp_lvl = 2'b10; rsp_lvl = 2'b01; tick(3);
        rd(8'h60, v);
        check("R5 status full", v, 8'h6F);
        wr(8'h60, 8'h00);
        rd(8'h60, v);
        check("R7 status write ignored", v, 8'h6F);
        rd(8'h42, v);
        check("R7 unmapped read", v, 8'h00);
        rd(8'h6C, v);
        check("R8 fault reg clean", v, 8'h00);
    endtask

    task automatic t_fault_alert();
        logic [7:0] v;
        rsp_lvl = 2'b00; tick(3);
        wr(8'h69, 8'hFF);
        pulse_fault(4'h2);
        check("R8 alert set", {7'h0, alert}, 8'h01);
        check("R9 alert-only gate", {4'h0, gate_on}, 8'h0F);
        check("R9 alert-only pg", {4'h0, pg_ok}, 8'h0F);
        rd(8'h6C, v);
        check("R8 fault bit", v, 8'h02);
        wr(8'h6C, 8'h01);
        rd(8'h6C, v);
        check("R8 other bit clear no effect", v, 8'h02);
        wr(8'h6C, 8'h02);
        check("R8 alert cleared", {7'h0, alert}, 8'h00);
        fault_crit = 4'h2;
        wr(8'h6C, 8'h02);
        fault_crit = 4'h0;
        rd(8'h6C, v);
        check("R8 set wins over clear", v, 8'h02);
        wr(8'h6C, 8'h0F);
    endtask

    task automatic t_prot_pg();
        rsp_lvl = 2'b01; tick(3);
        pulse_fault(4'h4);
        check("R9 pg dropped", {4'h0, pg_ok}, 8'h0B);
        check("R9 gate kept", {4'h0, gate_on}, 8'h0F);
        wr(8'h6C, 8'h04);
        check("R9 pg back", {4'h0, pg_ok}, 8'h0F);
    endtask

    task automatic t_prot_off();
        rsp_lvl = 2'b10; tick(3);
        pulse_fault(4'h1);
        check("R10 channel shut", {4'h0, gate_on}, 8'h0E);
        wr(8'h69, 8'hFF);
        check("R10 rewrite alone no effect", {4'h0, gate_on}, 8'h0E);
        wr(8'h69, 8'hFC);
        check("R10 pair cleared", {4'h0, gate_on}, 8'h0E);
        wr(8'h69, 8'hFF);
        check("R10 restored", {4'h0, gate_on}, 8'h0F);
        wr(8'h6C, 8'h01);
        check("R8 alert released", {7'h0, alert}, 8'h00);
    endtask

    initial begin
        rst = 1'b1; uvlo_ok = 1'b0; hw_en = 1'b1; on_lvl = 4'h0;
        grp_lvl = 2'b00; rsp_lvl = 2'b00; fault_crit = 4'h0;
        reg_we = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_boot_high();
        t_sync_latency();
        t_majority();
        t_lockout();
        t_status();
        t_fault_alert();
        t_prot_pg();
        t_prot_off();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule